// File: doc/BRIEF.md
# Refresh Scheduler with Thermal Derating and Self-Refresh Sequencing

This block sits beside the command arbiter of a DDR2-class memory controller that drives one or two ranks. A shared interval timer marks each point at which every awake rank owes one more auto-refresh. The timer runs at the full interval in the normal thermal zone. When the digital hot-zone flag is set, the interval is halved. Each rank keeps a count of refreshes that are owed but not yet issued. The rank raises a refresh request while that count is non-zero. When the count reaches its cap, the rank also raises an urgent flag and stops granting permission for any other command. The arbiter then has no choice but to refresh.

After the arbiter takes a refresh, the rank withholds permission for activates and further refreshes for the refresh cycle time. The block also owns the clock-enable pin of each rank. It drops the pin to enter self-refresh, but only when the controller reports that all banks of that rank are precharged. It keeps the pin low for a minimum number of cycles. After the pin rises again, non-read commands and reads each wait out their own exit delay.

All limits are given in controller clock cycles. The defaults assume a 2.5 ns clock: 3120 cycles per normal interval, 51 cycles of refresh cycle time, 55 cycles before a non-read command after exit, and 200 cycles before a read.

Top module: `refresh_keeper`

## Requirements
- R1: With `hot_i` low, a shared interval timer fires once every `REFI_CYC` cycles. Each firing adds one owed refresh to every rank that is not in self-refresh.
- R2: With `hot_i` high, the interval is `REFI_CYC/2` cycles. If the timer already stands past the new limit when the flag rises, it fires on the next cycle.
- R3: `ref_req_o[r]` is high when rank r owes at least one refresh, is awake, and is outside its refresh and non-read exit windows. A cycle with `ref_go_i[r]` and `ref_req_o[r]` both high takes one refresh and lowers the owed count by one. `ref_go_i[r]` has no effect while `ref_req_o[r]` is low.
- R4: The owed count saturates at `DEBT_CAP` (8). At the cap, `ref_urgent_o[r]` is high and both `act_ok_o[r]` and `rd_ok_o[r]` are low. If a refresh is taken in the same cycle the timer fires, the count stays unchanged.
- R5: For `RFC_CYC` cycles after a taken refresh, `act_ok_o[r]`, `rd_ok_o[r]` and `ref_req_o[r]` are low. The next refresh or activate may be issued exactly `RFC_CYC` cycles after the previous one.
- R6: An entry request takes effect only when all of the following hold: `all_pre_i[r]` is high, the rank is awake, and the rank is outside its refresh and non-read exit windows. A refresh taken in the same cycle wins over the entry. On entry, `cke_o[r]` falls on the next edge and the owed count clears. While `cke_o[r]` is low, the count stays zero and `ref_req_o`, `act_ok_o` and `rd_ok_o` stay low.
- R7: Once `cke_o[r]` falls, it stays low for at least `CKE_LOW_MIN` (3) cycles. An exit request made earlier than that is ignored.
- R8: After `cke_o[r]` rises, `act_ok_o[r]` and `ref_req_o[r]` stay low for `XSNR_CYC` cycles.
- R9: After `cke_o[r]` rises, `rd_ok_o[r]` stays low for `XSRD_CYC` cycles.
- R10: In reset, every `cke_o` is high, no rank owes a refresh, and `act_ok_o` and `rd_ok_o` are high.
- R11: Ranks are independent. Inputs for one rank never change the outputs of another, except through the shared interval timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| hot_i | input | 1 | Thermal zone flag; high selects the halved interval |
| ref_go_i | input | RANKS | Arbiter issues a refresh to the rank this cycle |
| all_pre_i | input | RANKS | All banks of the rank are precharged |
| sr_enter_i | input | RANKS | Request self-refresh entry |
| sr_exit_i | input | RANKS | Request self-refresh exit |
| ref_req_o | output | RANKS | Refresh owed and issuable |
| ref_urgent_o | output | RANKS | Owed count at cap; refresh cannot be deferred |
| act_ok_o | output | RANKS | Activates and other non-read commands permitted |
| rd_ok_o | output | RANKS | Read commands permitted |
| cke_o | output | RANKS | Clock-enable per rank; low in self-refresh |

## Verification
A miscounted owed count shows up at `ref_req_o` or `ref_urgent_o`. When the count is one too high, the request stays up one refresh too long, which is visible one refresh cycle time after the expected last grant. A count that fails to saturate shows as a missing urgent flag, one interval after the eighth missed refresh. A window counter that is off by one moves the rising edge of `act_ok_o` or `rd_ok_o` by one cycle. A wrong low-time count for the clock-enable moves the rising edge of `cke_o` while an exit request is held. The reference model compares every output of every rank on every cycle, so each of these faults is reported in the cycle where it first appears.

// File: rtl/refresh_keeper.sv
module refresh_keeper #(
  parameter int RANKS       = 2,
  parameter int REFI_CYC    = 3120,
  parameter int RFC_CYC     = 51,
  parameter int XSNR_CYC    = 55,
  parameter int XSRD_CYC    = 200,
  parameter int CKE_LOW_MIN = 3,
  parameter int DEBT_CAP    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hot_i,
  input  logic [RANKS-1:0] ref_go_i,
  input  logic [RANKS-1:0] all_pre_i,
  input  logic [RANKS-1:0] sr_enter_i,
  input  logic [RANKS-1:0] sr_exit_i,
  output logic [RANKS-1:0] ref_req_o,
  output logic [RANKS-1:0] ref_urgent_o,
  output logic [RANKS-1:0] act_ok_o,
  output logic [RANKS-1:0] rd_ok_o,
  output logic [RANKS-1:0] cke_o
);
  localparam int TW = $clog2(REFI_CYC + 1);
  localparam int DW = $clog2(DEBT_CAP + 1);
  localparam int RW = $clog2(RFC_CYC + 1);
  localparam int NW = $clog2(XSNR_CYC + 1);
  localparam int SW = $clog2(XSRD_CYC + 1);
  localparam int LW = $clog2(CKE_LOW_MIN + 1);

  logic [TW-1:0] ivl_q;
  logic [TW-1:0] limit;
  logic          tick;

  assign limit = hot_i ? TW'(REFI_CYC / 2) : TW'(REFI_CYC);
  assign tick  = (ivl_q >= limit - 1'b1);

  always_ff @(posedge clk_i) begin
    if (!rst_ni)   ivl_q <= '0;
    else if (tick) ivl_q <= '0;
    else           ivl_q <= ivl_q + 1'b1;
  end

  for (genvar g = 0; g < RANKS; g++) begin : g_rank
    logic [DW-1:0] debt_q;
    logic [RW-1:0] rfc_q;
    logic [NW-1:0] xsnr_q;
    logic [SW-1:0] xsrd_q;
    logic [LW-1:0] low_q;
    logic          sr_q;
    logic          quiet, full, take, inc, go_sr, leave;

    assign quiet = !sr_q && (rfc_q == '0) && (xsnr_q == '0);
    assign full  = (debt_q == DW'(DEBT_CAP));
    assign take  = ref_go_i[g] && ref_req_o[g];
    assign inc   = tick && (!full || take);
    assign go_sr = sr_enter_i[g] && all_pre_i[g] && quiet && !take;
    assign leave = sr_exit_i[g] && sr_q && (low_q >= LW'(CKE_LOW_MIN));

    assign ref_req_o[g]    = quiet && (debt_q != '0);
    assign ref_urgent_o[g] = !sr_q && full;
    assign act_ok_o[g]     = quiet && !full;
    assign rd_ok_o[g]      = !sr_q && (rfc_q == '0) && (xsrd_q == '0) && !full;
    assign cke_o[g]        = !sr_q;

    always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
        debt_q <= '0;
        rfc_q  <= '0;
        xsnr_q <= '0;
        xsrd_q <= '0;
        low_q  <= '0;
        sr_q   <= 1'b0;
      end else begin
        if (go_sr || sr_q) debt_q <= '0;
        else               debt_q <= debt_q + DW'(inc) - DW'(take);

        if (take)               rfc_q <= RW'(RFC_CYC - 1);
        else if (rfc_q != '0)   rfc_q <= rfc_q - 1'b1;

        if (leave)              xsnr_q <= NW'(XSNR_CYC - 1);
        else if (xsnr_q != '0)  xsnr_q <= xsnr_q - 1'b1;

        if (leave)              xsrd_q <= SW'(XSRD_CYC - 1);
        else if (xsrd_q != '0)  xsrd_q <= xsrd_q - 1'b1;

        if (go_sr)                                       low_q <= LW'(1);
        else if (sr_q && (low_q < LW'(CKE_LOW_MIN)))     low_q <= low_q + 1'b1;

        if (go_sr)      sr_q <= 1'b1;
        else if (leave) sr_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/refresh_keeper_chk.sv
module refresh_keeper_chk #(
  parameter int RANKS = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [RANKS-1:0] ref_go_i,
  input logic [RANKS-1:0] all_pre_i,
  input logic [RANKS-1:0] sr_enter_i,
  input logic [RANKS-1:0] sr_exit_i,
  input logic [RANKS-1:0] ref_req_o,
  input logic [RANKS-1:0] ref_urgent_o,
  input logic [RANKS-1:0] act_ok_o,
  input logic [RANKS-1:0] rd_ok_o,
  input logic [RANKS-1:0] cke_o
);
  for (genvar r = 0; r < RANKS; r++) begin : g_chk
    assert_urgent_blocks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ref_urgent_o[r] |-> (!act_ok_o[r] && !rd_ok_o[r]));

    assert_rfc_holdoff_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ref_go_i[r] && ref_req_o[r]) |=> (!act_ok_o[r] && !ref_req_o[r] && !rd_ok_o[r]));

    assert_entry_guarded_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(cke_o[r]) |-> $past(sr_enter_i[r] && all_pre_i[r]));

    assert_asleep_silent_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cke_o[r] |-> (!ref_req_o[r] && !act_ok_o[r] && !rd_ok_o[r]));

    assert_low_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(cke_o[r]) |=> ##1 !cke_o[r]);

    assert_early_exit_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sr_exit_i[r] && $fell(cke_o[r])) |=> !cke_o[r]);

    assert_exit_windows_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(cke_o[r]) |-> (!act_ok_o[r] && !rd_ok_o[r] && !ref_req_o[r]));
  end
endmodule

bind refresh_keeper refresh_keeper_chk #(.RANKS(RANKS)) chk_i (.*);

// File: tb/refresh_keeper_tb_top.sv
module refresh_keeper_tb_top;
  localparam int NR   = 2;
  localparam int REFI = 160;
  localparam int RFC  = 51;
  localparam int XSNR = 55;
  localparam int XSRD = 200;
  localparam int LOWM = 3;
  localparam int CAP  = 8;
  localparam int NCYC = 25000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hot = 1'b0;
  logic [NR-1:0] go = '0, pre = '0, ent = '0, ext = '0;
  logic [NR-1:0] req, urg, act, rd, cke;

  always #2 clk = ~clk;

  refresh_keeper #(.RANKS(NR), .REFI_CYC(REFI), .RFC_CYC(RFC), .XSNR_CYC(XSNR),
                   .XSRD_CYC(XSRD), .CKE_LOW_MIN(LOWM), .DEBT_CAP(CAP)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .hot_i(hot), .ref_go_i(go), .all_pre_i(pre),
    .sr_enter_i(ent), .sr_exit_i(ext), .ref_req_o(req), .ref_urgent_o(urg),
    .act_ok_o(act), .rd_ok_o(rd), .cke_o(cke));

  int compared = 0, mismatched = 0;
  int ivl = 0;
  int debt[NR], rfcw[NR], xn[NR], xr[NR], lowc[NR];
  bit asleep[NR];

  function automatic bit m_quiet(int r);
    return !asleep[r] && rfcw[r] == 0 && xn[r] == 0;
  endfunction
  function automatic bit m_req(int r); return m_quiet(r) && debt[r] > 0; endfunction
  function automatic bit m_urg(int r); return !asleep[r] && debt[r] == CAP; endfunction
  function automatic bit m_act(int r); return m_quiet(r) && debt[r] < CAP; endfunction
  function automatic bit m_rd(int r);
    return !asleep[r] && rfcw[r] == 0 && xr[r] == 0 && debt[r] < CAP;
  endfunction

  task automatic chk(string tag, int r, logic got, bit exp, int cyc);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s rank %0d cycle %0d: got %0b expected %0b", tag, r, cyc, got, exp);
    end
  endtask

  task automatic compare_all(int cyc);
    for (int r = 0; r < NR; r++) begin
      if (!rst_n) begin
        chk("R10 cke", r, cke[r], 1'b1, cyc);
        chk("R10 req", r, req[r], 1'b0, cyc);
        chk("R10 act", r, act[r], 1'b1, cyc);
        chk("R10 rd",  r, rd[r],  1'b1, cyc);
      end else begin
        chk("R6/R7 cke",    r, cke[r], !asleep[r], cyc);
        chk("R1/R2/R3 req", r, req[r], m_req(r), cyc);
        chk("R4 urgent",    r, urg[r], m_urg(r), cyc);
        chk("R5/R8 act_ok", r, act[r], m_act(r), cyc);
        chk("R9 rd_ok",     r, rd[r],  m_rd(r), cyc);
      end
    end
  endtask

  task automatic step();
    int lim;
    bit tick;
    lim  = hot ? REFI / 2 : REFI;
    tick = ivl >= lim - 1;
    ivl  = tick ? 0 : ivl + 1;
    for (int r = 0; r < NR; r++) begin
      bit take, into, outof, full;
      full  = debt[r] == CAP;
      take  = go[r] && m_req(r);
      into  = ent[r] && pre[r] && m_quiet(r) && !take;
      outof = ext[r] && asleep[r] && lowc[r] >= LOWM;
      if (into || asleep[r]) debt[r] = 0;
      else begin
        if (tick && (!full || take)) debt[r]++;
        if (take) debt[r]--;
      end
      if (take) rfcw[r] = RFC - 1; else if (rfcw[r] > 0) rfcw[r]--;
      if (outof) begin xn[r] = XSNR - 1; xr[r] = XSRD - 1; end
      else begin
        if (xn[r] > 0) xn[r]--;
        if (xr[r] > 0) xr[r]--;
      end
      if (into) lowc[r] = 1; else if (asleep[r] && lowc[r] < LOWM) lowc[r]++;
      if (into) asleep[r] = 1; else if (outof) asleep[r] = 0;
    end
  endtask

  // Schedule: reset (R10); rank1 starves to the cap while rank0 is served (R1, R4, R11);
  // drain (R3, R5); hot zone (R2); self-refresh entry/exit (R6..R9); then random traffic.
  task automatic drive(int cyc);
    rst_n = (cyc >= 4);
    if (cyc < 2000) begin
      go = 2'b01;
    end else if (cyc < 2700) begin
      go = 2'b11;
    end else if (cyc < 4000) begin
      hot = 1'b1; go = 2'b11;
    end else if (cyc < 4500) begin
      hot = 1'b0;
      go  = 2'b01;
      pre = (cyc >= 4010) ? 2'b10 : 2'b00;
      ent = (cyc < 4060) ? 2'b10 : 2'b00;
      ext = (cyc >= 4061 && cyc < 4070) ? 2'b10 : 2'b00;
    end else if (cyc < 5000) begin
      go  = 2'b00;
      pre = 2'b01;
      ent = (cyc >= 4600 && cyc < 4602) ? 2'b01 : 2'b00;
      ext = (cyc >= 4600 && cyc < 4700) ? 2'b01 : 2'b00;
    end else begin
      if (cyc % 3000 == 0) hot = ~hot;
      for (int r = 0; r < NR; r++) begin
        go[r]  = ($urandom % 4) == 0;
        pre[r] = ($urandom % 2) == 0;
        ent[r] = ($urandom % 32) == 0;
        ext[r] = ($urandom % 16) == 0;
      end
    end
  endtask

  initial begin
    for (int r = 0; r < NR; r++) begin
      debt[r] = 0; rfcw[r] = 0; xn[r] = 0; xr[r] = 0; lowc[r] = 0; asleep[r] = 0;
    end
    for (int cyc = 0; cyc < NCYC; cyc++) begin
      @(negedge clk);
      compare_all(cyc);
      drive(cyc);
      @(posedge clk);
      #1;
      if (rst_n) step();
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #((NCYC + 1000) * 4);
    mismatched++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule